// File: doc/BRIEF.md
# Pipelined Dual-Port Synchronous RAM

This block is a word-addressed memory with two independent access ports, A and B, that share one array. Each port has a write strobe, an address, a 36-bit data word split into four 9-bit byte lanes with one enable per lane, and a pair of chip selects of opposite polarity. Each port registers its controls, address and write data on the rising clock edge. On the next edge it performs the access. A read result is held in an output register. Both ports may reach any word in the same cycle, and one port may read a word while the other port writes it.

A port is selected only when its active-low select is low and its active-high select is high. When a deselected cycle is followed by selected cycles, the port needs one selected cycle to wake up before read data reaches the pins again. A read issued in that wake-up cycle returns nothing. Each port's read data comes with an `rvalid` flag. While the flag is low, the data bus is held at zero.

If both ports write the same word in the same cycle, the stored result is undefined. Users must avoid this case.

Top module: `dpr_dual_ram`

## Requirements
- R1: A read on a port that was selected in the cycle before it and is selected in its own cycle puts the addressed word on that port's rdata with rvalid high. This happens in the second clock cycle after the one in which the address was presented, so the latency is two rising edges. The output holds for one cycle per read.
- R2: Suppose one port reads an address in the same cycle that the other port writes it. The read returns the word stored before that write, and a read in a later cycle returns the new word.
- R3: On a write, byte enable bit i controls lane i, which is wdata bits [9i+8:9i]. A lane whose enable bit is 0 keeps its stored contents.
- R4: A port is selected only when its ce_n input is 0 and its ce input is 1. A deselected cycle neither changes memory nor produces a read output, whatever the state of the write strobe.
- R5: A read issued in the first selected cycle after a deselected cycle (or after reset) produces no output. In its output cycle, rvalid is 0 and rdata is 0.
- R6: Whenever rvalid is 0, rdata is all zero. A write cycle leaves rvalid at 0 in the cycle where a read result would be due.
- R7: While rst is high on a rising edge, both ports are cleared: rvalid and rdata read 0 after that edge, and the port counts as deselected for the wake-up rule.
- R8: The two ports operate independently. Accesses to different addresses on A and B in the same cycle each complete with their own two-edge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for both ports |
| rst | input | 1 | Synchronous active-high reset of the pipeline state |
| a_ce_n | input | 1 | Port A select, active low |
| a_ce | input | 1 | Port A select, active high |
| a_we | input | 1 | Port A write strobe (1 = write, 0 = read) |
| a_addr | input | ADDR_W | Port A word address |
| a_be | input | LANES | Port A byte-lane write enables |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A read data, zero when not valid |
| a_rvalid | output | 1 | Port A read data valid |
| b_ce_n | input | 1 | Port B select, active low |
| b_ce | input | 1 | Port B select, active high |
| b_we | input | 1 | Port B write strobe (1 = write, 0 = read) |
| b_addr | input | ADDR_W | Port B word address |
| b_be | input | LANES | Port B byte-lane write enables |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B read data, zero when not valid |
| b_rvalid | output | 1 | Port B read data valid |

## Verification
A read result is due on the second rising edge after its address is driven, and a write becomes visible to reads issued from the next cycle on. Whether the result is valid depends on the select state in the read's own cycle and in the cycle before it. The bench drives each cycle's inputs on a falling edge and computes the expected rvalid and rdata for both ports at that moment. It uses a word model that it updates only after both reads of that cycle are resolved. It then holds that expectation in a two-deep queue and compares it on the falling edge two cycles later, when the output register has settled.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  localparam int NPORTS = 2;

  // A port takes part in a cycle only with both of its selects active.
  function automatic logic port_selected(input logic ce_n, input logic ce);
    return !ce_n && ce;
  endfunction

endpackage

// File: rtl/dpr_port_front.sv
module dpr_port_front
  import dpr_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              ce,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic              cs_q,
  output logic              we_q,
  output logic              awake_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [LANES-1:0]  be_q,
  output logic [DATA_W-1:0] wdata_q
);

  // Control registers carry reset; awake_q remembers that the previous
  // cycle was selected, which gates read output after a deselect.
  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q    <= 1'b0;
      we_q    <= 1'b0;
      awake_q <= 1'b0;
    end else begin
      cs_q    <= port_selected(ce_n, ce);
      we_q    <= we;
      awake_q <= cs_q;
    end
  end

  // Datapath registers need no reset: cs_q qualifies every use.
  always_ff @(posedge clk) begin
    addr_q  <= addr;
    be_q    <= be;
    wdata_q <= wdata;
  end

endmodule

// File: rtl/dpr_mem_core.sv
module dpr_mem_core #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  parameter int DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_wr,
  input  logic              a_rd,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANES-1:0]  a_be,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_q,
  input  logic              b_wr,
  input  logic              b_rd,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANES-1:0]  b_be,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_q
);

  logic [DATA_W-1:0] mem [DEPTH];

  // Reads sample the array before this edge's writes land, so a read
  // colliding with the other port's write returns the old word.
  always_ff @(posedge clk) begin
    if (a_rd) a_q <= mem[a_addr];
    if (b_rd) b_q <= mem[b_addr];
    for (int i = 0; i < LANES; i++) begin
      if (a_wr && a_be[i]) mem[a_addr][i*LANE_W +: LANE_W] <= a_wdata[i*LANE_W +: LANE_W];
      if (b_wr && b_be[i]) mem[b_addr][i*LANE_W +: LANE_W] <= b_wdata[i*LANE_W +: LANE_W];
    end
  end

  AST_OLD_DATA: assert property (@(posedge clk) disable iff (rst)
    (a_rd && b_wr && (a_addr == b_addr)) |=> (a_q === $past(mem[a_addr]))); // R2

  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (!a_wr && !(b_wr && (b_addr == a_addr))) |=> (mem[$past(a_addr)] === $past(mem[a_addr]))); // R4

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    AST_LANE_KEEP: assert property (@(posedge clk) disable iff (rst)
      (a_wr && !a_be[i] && !(b_wr && (b_addr == a_addr)))
      |=> (mem[$past(a_addr)][i*LANE_W +: LANE_W] === $past(mem[a_addr][i*LANE_W +: LANE_W]))); // R3
  end

endmodule

// File: rtl/dpr_out_stage.sv
module dpr_out_stage #(
  parameter int DATA_W = 36
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fire,
  input  logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);

  logic valid_q;

  always_ff @(posedge clk) begin
    if (rst) valid_q <= 1'b0;
    else     valid_q <= fire;
  end

  assign rvalid = valid_q;
  assign rdata  = valid_q ? q : '0;

  AST_RST_QUIET: assert property (@(posedge clk) rst |=> !rvalid); // R7

endmodule

// File: rtl/dpr_dual_ram.sv
module dpr_dual_ram
  import dpr_pkg::*;
#(
  parameter int DEPTH  = 1024,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_ce_n,
  input  logic              a_ce,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANES-1:0]  a_be,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_rvalid,
  input  logic              b_ce_n,
  input  logic              b_ce,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANES-1:0]  b_be,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_rvalid
);

  logic              cen_in   [NPORTS];
  logic              ce_in    [NPORTS];
  logic              we_in    [NPORTS];
  logic [ADDR_W-1:0] addr_in  [NPORTS];
  logic [LANES-1:0]  be_in    [NPORTS];
  logic [DATA_W-1:0] wdata_in [NPORTS];
  logic              sel_in   [NPORTS];

  logic              cs_q     [NPORTS];
  logic              we_q     [NPORTS];
  logic              awake_q  [NPORTS];
  logic [ADDR_W-1:0] addr_q   [NPORTS];
  logic [LANES-1:0]  be_q     [NPORTS];
  logic [DATA_W-1:0] wdata_q  [NPORTS];
  logic              wr_en    [NPORTS];
  logic              rd_en    [NPORTS];
  logic              fire     [NPORTS];
  logic [DATA_W-1:0] mem_q    [NPORTS];
  logic [DATA_W-1:0] rdata_o  [NPORTS];
  logic              rvalid_o [NPORTS];

  assign cen_in[0] = a_ce_n;  assign cen_in[1] = b_ce_n;
  assign ce_in[0]  = a_ce;    assign ce_in[1]  = b_ce;
  assign we_in[0]  = a_we;    assign we_in[1]  = b_we;
  assign addr_in[0]  = a_addr;  assign addr_in[1]  = b_addr;
  assign be_in[0]    = a_be;    assign be_in[1]    = b_be;
  assign wdata_in[0] = a_wdata; assign wdata_in[1] = b_wdata;

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    assign sel_in[p] = port_selected(cen_in[p], ce_in[p]);

    dpr_port_front #(.ADDR_W(ADDR_W), .LANES(LANES), .DATA_W(DATA_W)) u_front (
      .clk     (clk),
      .rst     (rst),
      .ce_n    (cen_in[p]),
      .ce      (ce_in[p]),
      .we      (we_in[p]),
      .addr    (addr_in[p]),
      .be      (be_in[p]),
      .wdata   (wdata_in[p]),
      .cs_q    (cs_q[p]),
      .we_q    (we_q[p]),
      .awake_q (awake_q[p]),
      .addr_q  (addr_q[p]),
      .be_q    (be_q[p]),
      .wdata_q (wdata_q[p])
    );

    assign wr_en[p] = cs_q[p] & we_q[p];
    assign rd_en[p] = cs_q[p] & ~we_q[p];
    assign fire[p]  = rd_en[p] & awake_q[p];

    dpr_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk    (clk),
      .rst    (rst),
      .fire   (fire[p]),
      .q      (mem_q[p]),
      .rdata  (rdata_o[p]),
      .rvalid (rvalid_o[p])
    );

    AST_READ_DUE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst, 1) && !$past(rst, 2) && !$past(rst, 3) &&
       $past(sel_in[p], 2) && !$past(we_in[p], 2) && $past(sel_in[p], 3)) |-> rvalid_o[p]); // R1

    AST_DRIVE_NEEDS_WAKE: assert property (@(posedge clk) disable iff (rst)
      rvalid_o[p] |-> ($past(sel_in[p], 2) && $past(sel_in[p], 3))); // R5

    AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
      ($past(sel_in[p], 2) && $past(we_in[p], 2)) |-> !rvalid_o[p]); // R6
  end

  dpr_mem_core #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W), .DATA_W(DATA_W)
  ) u_mem (
    .clk     (clk),
    .rst     (rst),
    .a_wr    (wr_en[0]),
    .a_rd    (rd_en[0]),
    .a_addr  (addr_q[0]),
    .a_be    (be_q[0]),
    .a_wdata (wdata_q[0]),
    .a_q     (mem_q[0]),
    .b_wr    (wr_en[1]),
    .b_rd    (rd_en[1]),
    .b_addr  (addr_q[1]),
    .b_be    (be_q[1]),
    .b_wdata (wdata_q[1]),
    .b_q     (mem_q[1])
  );

  assign a_rdata  = rdata_o[0];
  assign a_rvalid = rvalid_o[0];
  assign b_rdata  = rdata_o[1];
  assign b_rvalid = rvalid_o[1];

endmodule

// File: tb/tb_dpr_dual_ram.sv
`timescale 1ns/1ps
module tb_dpr_dual_ram;

  localparam int DEPTH = 1024;
  localparam int AW    = 10;
  localparam int DW    = 36;
  localparam int LN    = 4;
  localparam int LW    = 9;

  typedef struct packed {
    logic          cen;
    logic          ce;
    logic          we;
    logic [AW-1:0] addr;
    logic [LN-1:0] be;
    logic [DW-1:0] wd;
  } req_t;

  logic          clk = 1'b0;
  logic          rst;
  logic          a_ce_n, a_ce, a_we, b_ce_n, b_ce, b_we;
  logic [AW-1:0] a_addr, b_addr;
  logic [LN-1:0] a_be, b_be;
  logic [DW-1:0] a_wdata, b_wdata, a_rdata, b_rdata;
  logic          a_rvalid, b_rvalid;

  always #2.5 clk = ~clk;

  dpr_dual_ram #(.DEPTH(DEPTH), .LANES(LN), .LANE_W(LW)) dut (
    .clk(clk), .rst(rst),
    .a_ce_n(a_ce_n), .a_ce(a_ce), .a_we(a_we), .a_addr(a_addr), .a_be(a_be),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_rvalid(a_rvalid),
    .b_ce_n(b_ce_n), .b_ce(b_ce), .b_we(b_we), .b_addr(b_addr), .b_be(b_be),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_rvalid(b_rvalid)
  );

  logic [DW-1:0] model [DEPTH];
  logic          e1_chk [2], e2_chk [2], e1_v [2], e2_v [2], prev_sel [2];
  logic [DW-1:0] e1_d [2], e2_d [2];
  string         e1_t [2], e2_t [2];
  int            checks = 0;
  int            fails  = 0;
  bit            done   = 1'b0;

  function automatic req_t mk_rd(input logic [AW-1:0] a);
    req_t r; r = '0; r.ce = 1'b1; r.addr = a; return r;
  endfunction

  function automatic req_t mk_wr(input logic [AW-1:0] a, input logic [LN-1:0] be, input logic [DW-1:0] d);
    req_t r; r = '0; r.ce = 1'b1; r.we = 1'b1; r.addr = a; r.be = be; r.wd = d; return r;
  endfunction

  // variant 0: active-low select high; variant 1: active-high select low
  function automatic req_t mk_off(input bit variant, input req_t base);
    req_t r; r = base;
    if (variant) begin r.cen = 1'b0; r.ce = 1'b0; end
    else         begin r.cen = 1'b1; r.ce = 1'b1; end
    return r;
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw, input logic [LN-1:0] be);
    logic [DW-1:0] m; m = old;
    for (int i = 0; i < LN; i++) if (be[i]) m[i*LW +: LW] = nw[i*LW +: LW];
    return m;
  endfunction

  task automatic check_port(input int p);
    logic          gv;
    logic [DW-1:0] gd;
    gv = (p == 0) ? a_rvalid : b_rvalid;
    gd = (p == 0) ? a_rdata  : b_rdata;
    checks++;
    if (gv !== e2_v[p] || gd !== e2_d[p]) begin
      fails++;
      $display("FAIL %s port %0d: rvalid=%0b rdata=%h expected rvalid=%0b rdata=%h",
               e2_t[p], p, gv, gd, e2_v[p], e2_d[p]);
    end
  endtask

  task automatic do_cycle(input req_t ra, input req_t rb, input logic rst_v, input string tag);
    req_t r [2];
    logic sel [2];
    @(negedge clk);
    for (int p = 0; p < 2; p++) if (e2_chk[p]) check_port(p);
    for (int p = 0; p < 2; p++) begin
      e2_chk[p] = e1_chk[p]; e2_v[p] = e1_v[p]; e2_d[p] = e1_d[p]; e2_t[p] = e1_t[p];
    end
    r[0] = ra; r[1] = rb;
    rst = rst_v;
    a_ce_n = ra.cen; a_ce = ra.ce; a_we = ra.we; a_addr = ra.addr; a_be = ra.be; a_wdata = ra.wd;
    b_ce_n = rb.cen; b_ce = rb.ce; b_we = rb.we; b_addr = rb.addr; b_be = rb.be; b_wdata = rb.wd;
    for (int p = 0; p < 2; p++) sel[p] = !r[p].cen && r[p].ce && !rst_v;
    for (int p = 0; p < 2; p++) begin
      int o;
      string t;
      o = 1 - p;
      e1_chk[p] = 1'b1;
      e1_v[p]   = sel[p] && !r[p].we && prev_sel[p];
      e1_d[p]   = e1_v[p] ? model[r[p].addr] : '0;
      if (tag != "")                                               t = tag;
      else if (!sel[p])                                            t = "R4";
      else if (r[p].we)                                            t = "R6";
      else if (!prev_sel[p])                                       t = "R5";
      else if (sel[o] && r[o].we && r[o].addr == r[p].addr)        t = "R2";
      else                                                         t = "R1";
      e1_t[p] = t;
    end
    for (int p = 0; p < 2; p++)
      if (sel[p] && r[p].we) model[r[p].addr] = merge(model[r[p].addr], r[p].wd, r[p].be);
    for (int p = 0; p < 2; p++) prev_sel[p] = sel[p];
  endtask

  function automatic req_t rand_req();
    int unsigned k;
    logic [AW-1:0] a;
    k = $urandom_range(0, 99);
    a = ($urandom_range(0, 3) == 0) ? AW'($urandom_range(0, DEPTH-1)) : AW'($urandom_range(0, 15));
    if (k < 10)      return mk_off(k[0], mk_wr(a, 4'hF, {$urandom(), 4'h0}));
    else if (k < 50) return mk_wr(a, LN'($urandom_range(1, 15)), {$urandom(), 4'($urandom())});
    else             return mk_rd(a);
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    req_t ra, rb;
    void'($urandom(32'd20240611));
    rst = 1'b1;
    for (int p = 0; p < 2; p++) begin
      e1_chk[p] = 1'b0; e2_chk[p] = 1'b0; prev_sel[p] = 1'b0;
      e1_v[p] = 1'b0; e2_v[p] = 1'b0; e1_d[p] = '0; e2_d[p] = '0; e1_t[p] = ""; e2_t[p] = "";
    end
    a_ce_n = 1'b1; a_ce = 1'b0; a_we = 1'b0; a_addr = '0; a_be = '0; a_wdata = '0;
    b_ce_n = 1'b1; b_ce = 1'b0; b_we = 1'b0; b_addr = '0; b_be = '0; b_wdata = '0;

    // R7: reads presented under reset produce nothing
    for (int i = 0; i < 4; i++) do_cycle(mk_rd(AW'(i)), mk_rd(AW'(i + 1)), 1'b1, "R7");

    // Fill every word through both ports at once (R8)
    for (int i = 0; i < DEPTH / 2; i++)
      do_cycle(mk_wr(AW'(i), 4'hF, {$urandom(), 4'($urandom())}),
               mk_wr(AW'(i + DEPTH / 2), 4'hF, {$urandom(), 4'($urandom())}), 1'b0, "R8");

    // R1: back-to-back reads with both ports awake
    do_cycle(mk_rd(10'd3), mk_rd(10'd900), 1'b0, "R1");
    do_cycle(mk_rd(10'd4), mk_rd(10'd901), 1'b0, "R1");

    // R4: deselected writes by each select polarity, then reads prove no change
    do_cycle(mk_off(1'b0, mk_wr(10'd5, 4'hF, 36'h0_DEAD_BEEF)),
             mk_off(1'b1, mk_wr(10'd6, 4'hF, 36'h1_2345_6789)), 1'b0, "R4");
    // R5: first selected cycle after deselect does not drive
    do_cycle(mk_rd(10'd5), mk_rd(10'd6), 1'b0, "R5");
    do_cycle(mk_rd(10'd5), mk_rd(10'd6), 1'b0, "R4");

    // R2: A reads word 7 while B writes it, then A reads again
    do_cycle(mk_rd(10'd7), mk_wr(10'd7, 4'hF, 36'hA_5A5A_5A5A), 1'b0, "R2");
    do_cycle(mk_rd(10'd7), mk_rd(10'd8), 1'b0, "R2");
    // and the mirror case
    do_cycle(mk_wr(10'd8, 4'hF, 36'h3_C3C3_C3C3), mk_rd(10'd8), 1'b0, "R2");
    do_cycle(mk_rd(10'd9), mk_rd(10'd8), 1'b0, "R2");

    // R3: partial lane writes
    do_cycle(mk_wr(10'd9, 4'b0101, 36'hF_FFFF_FFFF), mk_wr(10'd11, 4'b1000, 36'h0_0000_0000), 1'b0, "R3");
    do_cycle(mk_rd(10'd9), mk_rd(10'd11), 1'b0, "R3");
    do_cycle(mk_rd(10'd9), mk_rd(10'd11), 1'b0, "R3");

    // R6: write cycles never drive read output
    do_cycle(mk_wr(10'd12, 4'hF, 36'h1_1111_1111), mk_wr(10'd13, 4'h3, 36'h2_2222_2222), 1'b0, "R6");
    // R8: independent reads on different words
    do_cycle(mk_rd(10'd20), mk_rd(10'd30), 1'b0, "R8");
    do_cycle(mk_wr(10'd40, 4'hF, 36'h4_4444_4444), mk_rd(10'd41), 1'b0, "R8");

    // Mixed random traffic, auto-tagged per port
    for (int i = 0; i < 3000; i++) begin
      ra = rand_req();
      rb = rand_req();
      if (ra.we && rb.we && ra.addr == rb.addr) rb.we = 1'b0;
      do_cycle(ra, rb, 1'b0, "");
    end

    for (int i = 0; i < 3; i++) do_cycle(mk_rd(10'd1), mk_rd(10'd2), 1'b0, "R1");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule